// File: doc/BRIEF.md
# Shared-Inverter AES Byte Substitution Unit

This unit computes, in one combinational pass, either the AES forward byte substitution or its inverse for a single 8-bit value. A single mode input selects the direction. It sits between a state register and the column-mixing logic of a byte-serial cipher core. The caller supplies a byte and a direction and reads the substituted byte back in the same cycle. The unit holds no state of its own.

The nonlinear step is a multiplicative inverse, and it is not taken from a 256-entry table. The byte is carried by a linear change of basis into a tower field: a degree-2 extension over GF(2^4), stored as a high and a low nibble. The inverse is formed there from a few nibble multiplies and squarings, and the result is carried back. Each change of basis is folded into the affine step next to it, so each side of the inverter has one linear network per direction. Both directions use the same single inverter.

Top module: `sbox_composite`

## Requirements
- R1: With `modeInv` low, `byteOut` equals the AES forward S-box value of `byteIn`, for every one of the 256 input values.
- R2: With `modeInv` high, `byteOut` equals the AES inverse S-box value of `byteIn`, for every one of the 256 input values.
- R3: In forward mode the input 0x00 gives 0x63, because the inverter maps zero to zero.
- R4: In inverse mode the input 0x63 gives 0x00.
- R5: Applying inverse mode to the forward-mode result of any byte returns that byte.
- R6: The unit is purely combinational. A change on `byteIn` or `modeInv` reaches `byteOut` within the same clock period, with no clock edge in between.
- R7: In either mode, `byteOut` never equals `byteIn` and never equals the bitwise complement of `byteIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| modeInv | input | 1 | Direction select: 0 gives the forward substitution, 1 gives the inverse |
| byteIn | input | 8 | Byte to substitute |
| byteOut | output | 8 | Substituted byte |

## Verification
The unit has no registers, so a fault in a basis matrix, the nibble arithmetic or an affine constant appears at `byteOut` at once. It shows up only for those input values whose bits reach the faulty term. The bench therefore sweeps every input byte in both directions and also checks the forward-then-inverse round trip. A wrong change of basis breaks the round trip for most bytes. A wrong zero handling in the inverter shows only at 0x00 forward and at 0x63 inverse, so those two values are checked on their own.

// File: rtl/sbox_gf_pkg.sv
package sbox_gf_pkg;

  // 8x8 GF(2) matrix stored by column: entry [j] is the image of basis bit j
  typedef logic [7:0][7:0] mat8_t;

  typedef struct packed {
    logic mapInverseIn;   // select the inverse-direction input network
    logic mapInverseOut;  // select the inverse-direction output network
  } sboxStrobe_t;

  // reduction terms: x^8+x^4+x^3+x+1 for the byte field, x^4+x+1 for nibbles
  localparam logic [7:0] BYTE_RED   = 8'h1B;
  localparam logic [3:0] NIB_RED    = 4'h3;
  // extension polynomial y^2 + y + LAMBDA, irreducible since Tr(LAMBDA)=1
  localparam logic [3:0] LAMBDA     = 4'hC;
  localparam logic [7:0] AFF_CONST  = 8'h63;
  localparam logic [7:0] IAFF_CONST = 8'h05;

  function automatic logic [3:0] gf4Mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] acc;
    logic [3:0] sh;
    logic       top;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) acc = acc ^ sh;
      top = sh[3];
      sh  = {sh[2:0], 1'b0};
      if (top) sh = sh ^ NIB_RED;
    end
    return acc;
  endfunction

  // multiply in the tower field; byte [7:4] is the y coefficient
  function automatic logic [7:0] cfMul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] hh;
    logic [3:0] hi;
    logic [3:0] lo;
    hh = gf4Mul(a[7:4], b[7:4]);
    hi = hh ^ gf4Mul(a[7:4], b[3:0]) ^ gf4Mul(a[3:0], b[7:4]);
    lo = gf4Mul(hh, LAMBDA) ^ gf4Mul(a[3:0], b[3:0]);
    return {hi, lo};
  endfunction

  function automatic logic isByteFieldRoot(input logic [7:0] c);
    logic [7:0] c2;
    logic [7:0] c3;
    logic [7:0] c4;
    logic [7:0] c8;
    c2 = cfMul(c, c);
    c3 = cfMul(c2, c);
    c4 = cfMul(c2, c2);
    c8 = cfMul(c4, c4);
    return (c8 ^ c4 ^ c3 ^ c ^ 8'h01) == 8'h00;
  endfunction

  function automatic logic [7:0] matApply(input mat8_t m, input logic [7:0] v);
    logic [7:0] acc;
    acc = '0;
    for (int j = 0; j < 8; j++) if (v[j]) acc = acc ^ m[j];
    return acc;
  endfunction

  function automatic logic [7:0] matRow(input mat8_t m, input int r);
    logic [7:0] row;
    for (int j = 0; j < 8; j++) row[j] = m[j][r];
    return row;
  endfunction

  function automatic logic [7:0] rotl1(input logic [7:0] x);
    return {x[6:0], x[7]};
  endfunction

  function automatic logic [7:0] affLin(input logic [7:0] x);
    logic [7:0] r1;
    logic [7:0] r2;
    logic [7:0] r3;
    r1 = rotl1(x);
    r2 = rotl1(r1);
    r3 = rotl1(r2);
    return x ^ r1 ^ r2 ^ r3 ^ rotl1(r3);
  endfunction

  function automatic logic [7:0] invAffLin(input logic [7:0] x);
    logic [7:0] r1;
    logic [7:0] r3;
    logic [7:0] r6;
    r1 = rotl1(x);
    r3 = rotl1(rotl1(r1));
    r6 = rotl1(rotl1(rotl1(r3)));
    return r1 ^ r3 ^ r6;
  endfunction

  // byte field -> tower field: bit j goes to root^j
  function automatic mat8_t buildIso();
    mat8_t      m;
    logic [7:0] root;
    logic [7:0] p;
    logic       found;
    root  = 8'h02;
    found = 1'b0;
    for (int c = 2; c < 256; c++) begin
      if (!found && isByteFieldRoot(8'(c))) begin
        root  = 8'(c);
        found = 1'b1;
      end
    end
    p = 8'h01;
    for (int j = 0; j < 8; j++) begin
      m[j] = p;
      p    = cfMul(p, root);
    end
    return m;
  endfunction

  function automatic mat8_t buildIsoInv(input mat8_t iso);
    mat8_t m;
    m = '0;
    for (int j = 0; j < 8; j++)
      for (int x = 0; x < 256; x++)
        if (matApply(iso, 8'(x)) == 8'(1 << j)) m[j] = 8'(x);
    return m;
  endfunction

  localparam mat8_t ISO     = buildIso();
  localparam mat8_t ISO_INV = buildIsoInv(ISO);

  function automatic mat8_t buildFwdOut();
    mat8_t m;
    for (int j = 0; j < 8; j++) m[j] = affLin(ISO_INV[j]);
    return m;
  endfunction

  function automatic mat8_t buildInvIn();
    mat8_t m;
    for (int j = 0; j < 8; j++) m[j] = matApply(ISO, invAffLin(8'(1 << j)));
    return m;
  endfunction

  // merged maps: (back-map then affine) and (inverse affine then forward map)
  localparam mat8_t      FWD_OUT_MAT  = buildFwdOut();
  localparam mat8_t      INV_IN_MAT   = buildInvIn();
  localparam logic [7:0] INV_IN_CONST = matApply(ISO, IAFF_CONST);

endpackage

// File: rtl/sbox_linmap.sv
module sbox_linmap
  import sbox_gf_pkg::*;
#(
  parameter mat8_t      MAT    = '0,
  parameter logic [7:0] OFFSET = 8'h00
) (
  input  logic [7:0] vecIn,
  output logic [7:0] vecOut
);

  for (genvar gi = 0; gi < 8; gi++) begin : g_row
    localparam logic [7:0] ROW = matRow(MAT, gi);
    assign vecOut[gi] = (^(ROW & vecIn)) ^ OFFSET[gi];
  end

endmodule

// File: rtl/sbox_cf_inverter.sv
module sbox_cf_inverter
  import sbox_gf_pkg::*;
(
  input  logic [7:0] cfIn,
  output logic [7:0] cfOut
);

  logic [3:0] hiNib, loNib;
  logic [3:0] hiSq, loSq, crossTerm, scaledHi;
  logic [3:0] normVal, norm2, norm4, norm8, norm6, normInv;

  always_comb begin
    hiNib     = cfIn[7:4];
    loNib     = cfIn[3:0];
    hiSq      = gf4Mul(hiNib, hiNib);
    loSq      = gf4Mul(loNib, loNib);
    crossTerm = gf4Mul(hiNib, loNib);
    scaledHi  = gf4Mul(hiSq, LAMBDA);
    normVal   = scaledHi ^ crossTerm ^ loSq;
    // nibble inverse as v^14 = v^2 * v^4 * v^8 (zero stays zero)
    norm2     = gf4Mul(normVal, normVal);
    norm4     = gf4Mul(norm2, norm2);
    norm8     = gf4Mul(norm4, norm4);
    norm6     = gf4Mul(norm2, norm4);
    normInv   = gf4Mul(norm6, norm8);
    cfOut     = {gf4Mul(hiNib, normInv), gf4Mul(hiNib ^ loNib, normInv)};
  end

endmodule

// File: rtl/sbox_ctrl.sv
module sbox_ctrl
  import sbox_gf_pkg::*;
(
  input  logic        modeInv,
  output sboxStrobe_t strobe
);

  always_comb begin
    strobe.mapInverseIn  = modeInv;
    strobe.mapInverseOut = modeInv;
  end

endmodule

// File: rtl/sbox_datapath.sv
module sbox_datapath
  import sbox_gf_pkg::*;
(
  input  logic [7:0]  byteIn,
  input  sboxStrobe_t strobe,
  output logic [7:0]  byteOut
);

  logic [7:0] fwdMapped, invMapped, cfIn, cfOut, fwdResult, invResult;

  sbox_linmap #(.MAT(ISO), .OFFSET(8'h00)) u_mapFwdIn (
    .vecIn (byteIn),
    .vecOut(fwdMapped)
  );

  sbox_linmap #(.MAT(INV_IN_MAT), .OFFSET(INV_IN_CONST)) u_mapInvIn (
    .vecIn (byteIn),
    .vecOut(invMapped)
  );

  assign cfIn = strobe.mapInverseIn ? invMapped : fwdMapped;

  sbox_cf_inverter u_inv (
    .cfIn (cfIn),
    .cfOut(cfOut)
  );

  sbox_linmap #(.MAT(FWD_OUT_MAT), .OFFSET(AFF_CONST)) u_mapFwdOut (
    .vecIn (cfOut),
    .vecOut(fwdResult)
  );

  sbox_linmap #(.MAT(ISO_INV), .OFFSET(8'h00)) u_mapInvOut (
    .vecIn (cfOut),
    .vecOut(invResult)
  );

  assign byteOut = strobe.mapInverseOut ? invResult : fwdResult;

endmodule

// File: rtl/sbox_composite.sv
module sbox_composite
  import sbox_gf_pkg::*;
(
  input  logic       modeInv,
  input  logic [7:0] byteIn,
  output logic [7:0] byteOut
);

  sboxStrobe_t strobe;

  sbox_ctrl u_ctrl (
    .modeInv(modeInv),
    .strobe (strobe)
  );

  sbox_datapath u_dp (
    .byteIn (byteIn),
    .strobe (strobe),
    .byteOut(byteOut)
  );

endmodule

// File: rtl/sbox_composite_chk.sv
module sbox_composite_chk (
  input logic       modeInv,
  input logic [7:0] byteIn,
  input logic [7:0] byteOut
);

  always_comb begin
    // R3
    if (!modeInv && byteIn == 8'h00)
      zero_fwd_chk: assert (byteOut == 8'h63) else $error("zero_fwd_chk");
    // R4
    if (modeInv && byteIn == 8'h63)
      zero_inv_chk: assert (byteOut == 8'h00) else $error("zero_inv_chk");
    // R7
    no_fixed_point_chk: assert (byteOut != byteIn) else $error("no_fixed_point_chk");
    // R7
    no_anti_fixed_chk: assert (byteOut != ~byteIn) else $error("no_anti_fixed_chk");
    // R2
    if (modeInv && byteIn == 8'h00)
      inv_of_zero_chk: assert (byteOut == 8'h52) else $error("inv_of_zero_chk");
  end

endmodule

bind sbox_composite sbox_composite_chk u_chk (
  .modeInv(modeInv),
  .byteIn (byteIn),
  .byteOut(byteOut)
);

// File: tb/sbox_composite_tb.sv
`timescale 1ns/1ps
module sbox_composite_tb;

  logic       clk = 1'b0;
  logic       modeInv;
  logic [7:0] byteIn;
  logic [7:0] byteOut;
  int         checks = 0;
  int         errors = 0;
  logic       done = 1'b0;
  logic [7:0] fwdRef [256];
  logic [7:0] invRef [256];

  always #10 clk = ~clk;

  sbox_composite u_dut (
    .modeInv(modeInv),
    .byteIn (byteIn),
    .byteOut(byteOut)
  );

  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc ^= sh;
      sh = sh[7] ? ((sh << 1) ^ 8'h1B) : (sh << 1);
    end
    return acc;
  endfunction

  function automatic logic [7:0] refAffine(input logic [7:0] x);
    logic [7:0] y;
    for (int i = 0; i < 8; i++)
      y[i] = x[i] ^ x[(i + 4) % 8] ^ x[(i + 5) % 8] ^ x[(i + 6) % 8] ^ x[(i + 7) % 8];
    return y ^ 8'h63;
  endfunction

  task automatic buildRef();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv;
      inv = 0;
      for (int y = 1; y < 256; y++)
        if (refMul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      fwdRef[x] = refAffine(inv);
    end
    for (int x = 0; x < 256; x++) invRef[fwdRef[x]] = 8'(x);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic apply(input logic m, input logic [7:0] b);
    @(posedge clk);
    modeInv <= m;
    byteIn  <= b;
    @(negedge clk);
  endtask

  task automatic testForwardSweep();  // R1
    for (int x = 0; x < 256; x++) begin
      apply(1'b0, 8'(x));
      check("R1", byteOut, fwdRef[x]);
    end
  endtask

  task automatic testInverseSweep();  // R2
    for (int x = 0; x < 256; x++) begin
      apply(1'b1, 8'(x));
      check("R2", byteOut, invRef[x]);
    end
  endtask

  task automatic testZeroCorners();
    apply(1'b0, 8'h00);
    check("R3", byteOut, 8'h63);
    apply(1'b1, 8'h63);
    check("R4", byteOut, 8'h00);
    apply(1'b0, 8'h01);
    check("R1", byteOut, 8'h7C);
    apply(1'b0, 8'h53);
    check("R1", byteOut, 8'hED);
    apply(1'b1, 8'h00);
    check("R2", byteOut, 8'h52);
  endtask

  task automatic testRoundTrip();  // R5
    for (int x = 0; x < 256; x++) begin
      logic [7:0] mid;
      apply(1'b0, 8'(x));
      mid = byteOut;
      apply(1'b1, mid);
      check("R5", byteOut, 8'(x));
    end
  endtask

  task automatic testCombinational();  // R6
    @(negedge clk);
    modeInv = 1'b0;
    byteIn  = 8'h53;
    #1;
    check("R6", byteOut, fwdRef[8'h53]);
    modeInv = 1'b1;
    #1;
    check("R6", byteOut, invRef[8'h53]);
    byteIn = 8'hA7;
    #1;
    check("R6", byteOut, invRef[8'hA7]);
    modeInv = 1'b0;
    #1;
    check("R6", byteOut, fwdRef[8'hA7]);
  endtask

  task automatic testNoFixedPoints();  // R7
    for (int m = 0; m < 2; m++) begin
      for (int x = 0; x < 256; x++) begin
        apply(m[0], 8'(x));
        checks++;
        if (byteOut == 8'(x) || byteOut == ~8'(x)) begin
          errors++;
          $display("FAIL R7 actual=%02h expected=not %02h and not %02h",
                   byteOut, 8'(x), ~8'(x));
        end
      end
    end
  endtask

  initial begin
    modeInv = 1'b0;
    byteIn  = 8'h00;
    buildRef();
    @(negedge clk);
    check("R3", byteOut, 8'h63);
    testZeroCorners();
    testForwardSweep();
    testInverseSweep();
    testRoundTrip();
    testCombinational();
    testNoFixedPoints();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule